// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns stereo PCM sample pairs into a one-bit serial stream for an audio codec or amplifier. It is a clock follower. The bit clock and the frame clock come in from outside. Both are brought into a fast system clock domain through two-flop synchronizers, and every data-change edge of the bit clock moves the transmitter one bit slot forward. A static configuration selects one of five alignment rules for the most significant bit relative to the frame edge:

- delayed-by-one stereo (I2S style)
- left-aligned
- right-aligned
- short-pulse frame with a one-bit delay
- short-pulse frame with no delay

Two further bits invert the sense of the bit clock and of the frame clock. The sample width is 16 or 24 bits.

Sample pairs arrive over a valid/ready handshake into a single holding register. The pair is moved into the shifter at the start of each frame. If no pair is waiting at that point, the frame carries silence and a sticky underrun flag is set.

Top module: `audio_ser_tx`

## Requirements
- R1: With `fmt_sel`=0 (delayed stereo), the MSB of each word appears one bit slot after the frame clock changes level. With a half-frame exactly as long as the word, the LSB falls into slot 0 of the next half.
- R2: With `fmt_sel`=1 (left-aligned), the MSB appears in the same slot in which the frame clock changes level.
- R3: With `fmt_sel`=2 (right-aligned), the LSB appears in the last slot before the next frame clock change. The MSB is therefore width slots before it, using the length of the previous half-frame.
- R4: With `fmt_sel`=3 (pulse frame, delayed), the left MSB appears one slot after the slot in which the frame pulse is high.
- R5: With `fmt_sel`=4 (pulse frame, undelayed), the left MSB appears in the slot of the frame pulse. In both pulse modes the right word follows the left word with no gap.
- R6: In the stereo formats a low (uninverted) frame clock carries the left word and a high one carries the right word. `inv_frame`=1 swaps that sense and the sense of the frame pulse. With `inv_bclk`=0 data changes on the falling bit-clock edge; with `inv_bclk`=1 it changes on the rising edge.
- R7: Slots not occupied by word bits are driven 0.
- R8: `width24`=1 sends bits 23..0 of each sample. `width24`=0 sends bits 15..0 and ignores bits 23..16.
- R9: `s_ready` is high exactly while the holding register is empty. An accepted pair drops `s_ready` until the next frame start moves the pair into the shifter.
- R10: A frame start with an empty holding register sends an all-zero frame and sets `underrun`. `underrun` stays set until reset.
- R11: In the cycle after reset, `sdata` is 0, `s_ready` is 1 and `underrun` is 0.
- R12: `sdata` changes only in the system cycle after a detected data-change edge of the bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | External bit clock |
| fclk_in | input | 1 | External frame / left-right clock |
| fmt_sel | input | 3 | Format: 0 delayed stereo, 1 left-aligned, 2 right-aligned, 3 pulse delayed, 4 pulse undelayed, 5-7 line held low |
| inv_bclk | input | 1 | Data changes on the rising rather than the falling bit-clock edge |
| inv_frame | input | 1 | Inverts the frame clock sense |
| width24 | input | 1 | 1: 24-bit samples, 0: 16-bit samples |
| s_valid | input | 1 | Sample pair offered |
| s_left | input | 24 | Left sample, right-aligned in the bus |
| s_right | input | 24 | Right sample, right-aligned in the bus |
| s_ready | output | 1 | Holding register empty |
| sdata | output | 1 | Serial data line |
| underrun | output | 1 | Sticky: a frame started with no pair waiting |

## Verification
Two situations are hard to reach from the ports. The first is a word that spills across a frame edge. This happens in the delayed formats when the half-frame, or the whole pulse frame, is exactly as long as the data. The last bit of the previous frame's right word then has to come out in slot 0 of the new frame. The stimulus produces these geometries on purpose, with a half-frame of 16 slots for 16-bit data.

The second is an underrun, which needs the feeder to miss a frame on purpose. The bench withholds one pair in a chosen frame, expects zeros there and the flag afterwards, and then resumes feeding. Around these directed cases, random formats, polarities, widths and frame lengths run with random samples. Every bit slot is compared with a bench model of the alignment rules.

// File: rtl/ast_pkg.sv
package ast_pkg;

  typedef enum logic [2:0] {
    FMT_STEREO_DLY = 3'd0,
    FMT_LEFT_ALGN  = 3'd1,
    FMT_RIGHT_ALGN = 3'd2,
    FMT_PULSE_DLY  = 3'd3,
    FMT_PULSE_NOW  = 3'd4
  } fmt_e;

  function automatic logic fmt_is_pulse(fmt_e f);
    return (f == FMT_PULSE_DLY) || (f == FMT_PULSE_NOW);
  endfunction

  function automatic logic fmt_is_delayed(fmt_e f);
    return (f == FMT_STEREO_DLY) || (f == FMT_PULSE_DLY);
  endfunction

endpackage

// File: rtl/ast_line_sync.sv
module ast_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic inv_i,
  output logic level_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= line_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], line_i};
      end
    end
  endgenerate

  assign level_o = chain_q[STAGES-1] ^ inv_i;

endmodule

// File: rtl/ast_slot_track.sv
module ast_slot_track #(
  parameter int CW   = 8,
  parameter int WARM = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bclk_n,
  input  logic          frame_n,
  input  logic          pulse_mode,
  output logic          fall_evt,
  output logic          frame_start,
  output logic [CW-1:0] pos_nx,
  output logic [CW-1:0] len_nx,
  output logic          half_nx
);

  localparam int WW = $clog2(WARM + 1);
  localparam logic [WW-1:0] WARM_C = WW'(WARM);

  logic          bclk_q;
  logic          frame_q;
  logic [CW-1:0] pos_q;
  logic [CW-1:0] len_q;
  logic [WW-1:0] warm_q;
  logic          restart;

  // edges are ignored until the synchronizers have filled after reset
  assign fall_evt = (warm_q == WARM_C) && bclk_q && !bclk_n;

  assign restart = pulse_mode ? (frame_n && !frame_q) : (frame_n != frame_q);

  assign frame_start = fall_evt &&
                       (pulse_mode ? (frame_n && !frame_q) : (!frame_n && frame_q));

  assign pos_nx  = restart ? '0 : pos_q + 1'b1;
  assign len_nx  = restart ? pos_q + 1'b1 : len_q;
  assign half_nx = frame_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q  <= 1'b1;
      frame_q <= 1'b1;
      pos_q   <= '1;
      len_q   <= '0;
      warm_q  <= '0;
    end else begin
      bclk_q <= bclk_n;
      if (warm_q != WARM_C) warm_q <= warm_q + 1'b1;
      if (fall_evt) begin
        frame_q <= frame_n;
        pos_q   <= pos_nx;
        len_q   <= len_nx;
      end
    end
  end

endmodule

// File: rtl/ast_sample_buf.sv
module ast_sample_buf #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  input  logic [DW-1:0] s_left,
  input  logic [DW-1:0] s_right,
  output logic          s_ready,
  input  logic          frame_start,
  output logic [DW-1:0] word_l,
  output logic [DW-1:0] word_r,
  output logic          underrun
);

  logic          full_q;
  logic          urun_q;
  logic [DW-1:0] hold_l, hold_r;
  logic [DW-1:0] cur_l,  cur_r;
  logic [DW-1:0] ld_l,   ld_r;
  logic          take;

  assign take    = s_valid && !full_q;
  assign s_ready = !full_q;
  assign ld_l    = full_q ? hold_l : '0;
  assign ld_r    = full_q ? hold_r : '0;

  // the new pair is visible in the same slot that starts the frame
  assign word_l   = frame_start ? ld_l : cur_l;
  assign word_r   = frame_start ? ld_r : cur_r;
  assign underrun = urun_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      urun_q <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
      cur_l  <= '0;
      cur_r  <= '0;
    end else begin
      if (take) begin
        hold_l <= s_left;
        hold_r <= s_right;
      end
      if (take)             full_q <= 1'b1;
      else if (frame_start) full_q <= 1'b0;
      if (frame_start) begin
        cur_l <= ld_l;
        cur_r <= ld_r;
        if (!full_q) urun_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ast_bit_pick.sv
module ast_bit_pick
  import ast_pkg::*;
#(
  parameter int DW       = 24,
  parameter int NARROW_W = 16,
  parameter int CW       = 8
) (
  input  fmt_e          fmt,
  input  logic          wide,
  input  logic [CW-1:0] pos,
  input  logic [CW-1:0] len,
  input  logic          half,
  input  logic [DW-1:0] word_l,
  input  logic [DW-1:0] word_r,
  output logic          base_bit
);

  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] DW_C = CW'(DW);
  localparam logic [CW-1:0] NW_C = CW'(NARROW_W);

  logic [CW-1:0] wid;
  logic [CW-1:0] wid2;
  logic [DW-1:0] word;
  logic [CW:0]   pos_plus_w;

  function automatic logic pick(logic [DW-1:0] w, logic [CW-1:0] idx);
    if (idx < DW_C) return w[idx[IW-1:0]];
    return 1'b0;
  endfunction

  assign wid        = wide ? DW_C : NW_C;
  assign wid2       = wid << 1;
  assign word       = half ? word_r : word_l;
  assign pos_plus_w = {1'b0, pos} + {1'b0, wid};

  always_comb begin
    base_bit = 1'b0;
    unique case (fmt)
      FMT_STEREO_DLY, FMT_LEFT_ALGN: begin
        if (pos < wid) base_bit = pick(word, wid - 1'b1 - pos);
      end
      FMT_RIGHT_ALGN: begin
        if ((pos < len) && (pos_plus_w >= {1'b0, len}))
          base_bit = pick(word, len - 1'b1 - pos);
      end
      FMT_PULSE_DLY, FMT_PULSE_NOW: begin
        if (pos < wid)       base_bit = pick(word_l, wid - 1'b1 - pos);
        else if (pos < wid2) base_bit = pick(word_r, wid2 - 1'b1 - pos);
      end
      default: base_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import ast_pkg::*;
#(
  parameter int DW          = 24,
  parameter int NARROW_W    = 16,
  parameter int MAX_HALF    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bclk_in,
  input  logic          fclk_in,
  input  logic [2:0]    fmt_sel,
  input  logic          inv_bclk,
  input  logic          inv_frame,
  input  logic          width24,
  input  logic          s_valid,
  input  logic [DW-1:0] s_left,
  input  logic [DW-1:0] s_right,
  output logic          s_ready,
  output logic          sdata,
  output logic          underrun
);

  localparam int CW = $clog2(2 * MAX_HALF) + 1;

  fmt_e          fmt;
  logic          bclk_n, frame_n;
  logic          fall_evt, frame_start, half_nx;
  logic [CW-1:0] pos_nx, len_nx;
  logic [DW-1:0] word_l, word_r;
  logic          base_bit;
  logic          dly_q, sdata_q;

  assign fmt = fmt_e'(fmt_sel);

  ast_line_sync #(.STAGES(SYNC_STAGES)) u_bclk_sync (
    .clk(clk), .rst(rst), .line_i(bclk_in), .inv_i(inv_bclk), .level_o(bclk_n)
  );

  ast_line_sync #(.STAGES(SYNC_STAGES)) u_frame_sync (
    .clk(clk), .rst(rst), .line_i(fclk_in), .inv_i(inv_frame), .level_o(frame_n)
  );

  ast_slot_track #(.CW(CW), .WARM(SYNC_STAGES + 1)) u_track (
    .clk(clk), .rst(rst), .bclk_n(bclk_n), .frame_n(frame_n),
    .pulse_mode(fmt_is_pulse(fmt)), .fall_evt(fall_evt),
    .frame_start(frame_start), .pos_nx(pos_nx), .len_nx(len_nx), .half_nx(half_nx)
  );

  ast_sample_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
    .s_ready(s_ready), .frame_start(frame_start), .word_l(word_l),
    .word_r(word_r), .underrun(underrun)
  );

  ast_bit_pick #(.DW(DW), .NARROW_W(NARROW_W), .CW(CW)) u_pick (
    .fmt(fmt), .wide(width24), .pos(pos_nx), .len(len_nx), .half(half_nx),
    .word_l(word_l), .word_r(word_r), .base_bit(base_bit)
  );

  // delayed formats replay the undelayed stream one slot later
  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q   <= 1'b0;
      sdata_q <= 1'b0;
    end else if (fall_evt) begin
      dly_q   <= base_bit;
      sdata_q <= fmt_is_delayed(fmt) ? dly_q : base_bit;
    end
  end

  assign sdata = sdata_q;

endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk (
  input logic clk,
  input logic rst,
  input logic s_valid,
  input logic s_ready,
  input logic sdata,
  input logic underrun,
  input logic fall_evt,
  input logic frame_start
);

  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (s_ready && !underrun && !sdata));

  assert_line_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(fall_evt) |-> $stable(sdata));

  assert_accept_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  assert_full_until_frame_R9: assert property (@(posedge clk) disable iff (rst)
    (!s_ready && !frame_start) |=> !s_ready);

  assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);

  assert_underrun_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> $past(frame_start && s_ready));

endmodule

bind audio_ser_tx audio_ser_tx_chk u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .sdata(sdata),
  .underrun(underrun), .fall_evt(fall_evt), .frame_start(frame_start)
);

// File: tb/audio_ser_tx_tb_top.sv
module audio_ser_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk_ln = 1'b1;
  logic        frame_ln = 1'b1;
  logic [2:0]  fmt_sel = 3'd0;
  logic        inv_bclk = 1'b0;
  logic        inv_frame = 1'b0;
  logic        width24 = 1'b0;
  logic        s_valid = 1'b0;
  logic [23:0] s_left = '0;
  logic [23:0] s_right = '0;
  logic        s_ready, sdata, underrun;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  audio_ser_tx dut_i (
    .clk(clk), .rst(rst), .bclk_in(bclk_ln), .fclk_in(frame_ln),
    .fmt_sel(fmt_sel), .inv_bclk(inv_bclk), .inv_frame(inv_frame),
    .width24(width24), .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
    .s_ready(s_ready), .sdata(sdata), .underrun(underrun)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp, int info);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (slot/info %0d) actual=%0b expected=%0b", req, info, act, exp);
    end
  endtask

  // model of the alignment rules; R7 zero padding and R8 width masking live here
  function automatic logic exp_bit(int f, int w, int n, int s,
                                   logic [23:0] l, logic [23:0] r, logic [23:0] pr);
    int h, p, q;
    logic [23:0] wd, pw;
    if (f <= 2) begin
      h  = (s >= n) ? 1 : 0;
      p  = s - h * n;
      wd = h ? r : l;
      pw = h ? l : pr;
      if (f == 0) begin
        if (p >= 1 && p <= w) return wd[w - p];
        if (p == 0 && w == n) return pw[0];
        return 1'b0;
      end
      if (f == 1) return (p < w) ? wd[w - 1 - p] : 1'b0;
      return (p >= n - w) ? wd[n - 1 - p] : 1'b0;
    end
    if (f == 4) q = s;
    else begin
      if (s == 0) return (w == n) ? pr[0] : 1'b0;
      q = s - 1;
    end
    if (q < w)     return l[w - 1 - q];
    if (q < 2 * w) return r[2 * w - 1 - q];
    return 1'b0;
  endfunction

  function automatic string fmt_tag(int f);
    case (f)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic half_lo(logic fr);
    bclk_ln  = inv_bclk;
    frame_ln = fr ^ inv_frame;
    tick(8);
  endtask

  task automatic half_hi();
    bclk_ln = ~inv_bclk;
    tick(8);
  endtask

  task automatic push(logic [23:0] l, logic [23:0] r);
    s_valid = 1'b1;
    s_left  = l;
    s_right = r;
    tick(1);
    s_valid = 1'b0;
    chk("R9 ready low after accept", s_ready, 1'b0, 0);
  endtask

  task automatic run_cfg(int f, logic ib, logic ifr, logic w24, int n, int skip);
    logic [23:0] pl[6];
    logic [23:0] pr[6];
    logic [23:0] prev_r;
    int w, nf, slots;
    logic dsp, fr;
    nf  = 5;
    w   = w24 ? 24 : 16;
    dsp = (f >= 3);
    for (int k = 0; k < nf; k++) begin
      pl[k] = 24'($urandom);
      pr[k] = 24'($urandom);
      if (k == skip) begin
        pl[k] = '0;
        pr[k] = '0;
      end
    end
    fmt_sel   = 3'(f);
    inv_bclk  = ib;
    inv_frame = ifr;
    width24   = w24;
    bclk_ln   = ~ib;
    frame_ln  = (dsp ? 1'b0 : 1'b1) ^ ifr;
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick(4);
    // R11 reset state
    chk("R11 sdata", sdata, 1'b0, 0);
    chk("R11 ready", s_ready, 1'b1, 0);
    chk("R11 underrun", underrun, 1'b0, 0);
    push(pl[0], pr[0]);
    for (int d = 0; d < (dsp ? 2 : n); d++) begin
      half_lo(dsp ? 1'b0 : 1'b1);
      half_hi();
    end
    prev_r = '0;
    slots  = 2 * n;
    for (int k = 0; k < nf; k++) begin
      for (int s = 0; s < slots; s++) begin
        fr = dsp ? (s == 0) : (s >= n);
        half_lo(fr);
        if (s == 2) begin
          chk("R9 ready after frame load", s_ready, 1'b1, k);
          if (k == 0) chk("R10 no underrun yet", underrun, 1'b0, k);
          if (k + 1 < nf && k + 1 != skip) push(pl[k + 1], pr[k + 1]);
        end
        // R6 polarity and R7/R8 covered by the configuration mix
        chk(fmt_tag(f), sdata, exp_bit(f, w, n, s, pl[k], pr[k], prev_r), s);
        half_hi();
      end
      prev_r = pr[k];
    end
    chk("R10 underrun flag", underrun, (skip >= 0) ? 1'b1 : 1'b0, skip);
  endtask

  initial begin
    void'($urandom(32'h5EED_A0D1));
    tick(3);
    // directed: exact-fit spill (R1, R4), padding (R7), polarities (R6), widths (R8)
    run_cfg(0, 1'b0, 1'b0, 1'b0, 16, -1);
    run_cfg(0, 1'b1, 1'b1, 1'b1, 32, -1);
    run_cfg(1, 1'b0, 1'b1, 1'b0, 20, -1);
    run_cfg(1, 1'b1, 1'b0, 1'b1, 24, -1);
    run_cfg(2, 1'b0, 1'b0, 1'b0, 32, -1);
    run_cfg(2, 1'b1, 1'b1, 1'b1, 28, -1);
    run_cfg(3, 1'b0, 1'b0, 1'b0, 16, -1);
    run_cfg(3, 1'b1, 1'b0, 1'b1, 32, -1);
    run_cfg(4, 1'b0, 1'b1, 1'b1, 24, -1);
    run_cfg(4, 1'b1, 1'b1, 1'b0, 20, -1);
    // R10 underrun: a withheld pair
    run_cfg(1, 1'b0, 1'b0, 1'b1, 32, 2);
    run_cfg(4, 1'b0, 1'b0, 1'b0, 16, 1);
    // random mix
    for (int i = 0; i < 4; i++) begin
      int f, wsel, n;
      f    = int'($urandom_range(0, 4));
      wsel = int'($urandom_range(0, 1));
      n    = (wsel != 0 ? 24 : 16) + int'($urandom_range(0, 8));
      run_cfg(f, 1'($urandom), 1'($urandom), 1'(wsel), n, -1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule